// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder

This block turns the 16-bit address bus and bus-control lines of a small 8-bit processor system into the select and strobe signals that memories and peripherals need. The lower half of the address space belongs to a single 32 KiB RAM. The upper half is split into eight 4 KiB blocks by a 1-of-8 decoder that is enabled only when the top address bit is set. The two highest blocks are merged into one 8 KiB ROM window. The remaining six blocks each select one peripheral slot.

All selects are active low, so they can drive device select pins directly. For every address exactly one select is low. Two active-low strobes, an output enable and a write enable, are formed from the read/write line and the phase-2 clock. Both strobes stay inactive while phase-2 is low.

The whole block is combinational. Its outputs follow its inputs with no clock latency.

Top module: `mmap_cs_decoder`

## Requirements
- R1: When addr_i[15] is 0 (0x0000 to 0x7FFF), ram_cs_n_o is 0 and rom_cs_n_o and every bit of io_cs_n_o are 1.
- R2: When addr_i[15] is 1, ram_cs_n_o is 1 and the block index addr_i[14:12] (4 KiB granularity, top nibble 0x8 to 0xF) alone picks the active select.
- R3: rom_cs_n_o is 0 exactly when addr_i[15:13] is 3'b111, which covers 0xE000 to 0xFFFF.
- R4: io_cs_n_o[k] is 0 exactly when the top nibble addr_i[15:12] equals 8+k, for k from 0 to 5 (0x8xxx maps to bit 0, up to 0xDxxx mapping to bit 5).
- R5: For every address value, exactly one of ram_cs_n_o, rom_cs_n_o and io_cs_n_o[5:0] is 0.
- R6: oe_n_o is 0 exactly when rw_i is 1 and phi2_i is 1.
- R7: we_n_o is 0 exactly when rw_i is 0 and phi2_i is 1.
- R8: While phi2_i is 0, both oe_n_o and we_n_o are 1 whatever the value of rw_i.
- R9: The outputs are a pure function of the present inputs: they hold their correct value after an input change, with no clock edge in between, and addr_i[11:0] has no effect on any select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Processor address bus |
| rw_i | input | 1 | Read/write line: 1 is read, 0 is write |
| phi2_i | input | 1 | Phase-2 clock; the strobes are qualified by it |
| ram_cs_n_o | output | 1 | RAM select, active low |
| rom_cs_n_o | output | 1 | ROM select, active low |
| io_cs_n_o | output | 6 | Peripheral slot selects, active low |
| oe_n_o | output | 1 | Output-enable strobe, active low |
| we_n_o | output | 1 | Write-enable strobe, active low |

## Verification
The bound checker runs on every evaluation. It checks that exactly one select is low, that the RAM select tracks the top address bit, that the ROM select covers the top 8 KiB, that the internal block decoder is one-hot when enabled and idle otherwise, and that the two strobes are never both active and are quiet in the low clock phase. Other properties are shown only by the bench's scenarios. These include that each peripheral select lands on its own nibble in the stated order, that the low twelve address bits have no effect, and that outputs settle without a clock edge. The bench covers these with a directed sweep of all sixteen top nibbles at both block edges, crossed with both read/write values and both clock phases, followed by seeded random vectors.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  // Address bus geometry
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned BLK_BITS  = 3;   // bits feeding the 1-of-N block decoder
  localparam int unsigned ROM_BLKS  = 2;   // highest blocks merged into the ROM window
  localparam int unsigned NUM_BLK   = 1 << BLK_BITS;
  localparam int unsigned IO_SLOTS  = NUM_BLK - ROM_BLKS;
  localparam int unsigned BLK_SHIFT = ADDR_W - 1 - BLK_BITS;
  localparam int unsigned NIB_W     = BLK_BITS + 1;

  // Upper address field: half-select bit plus block index
  function automatic logic [NIB_W-1:0] top_field(input logic [ADDR_W-1:0] a);
    return NIB_W'(a >> BLK_SHIFT);
  endfunction

  // True when the address lies in the upper half (block decoder enabled)
  function automatic logic upper_half(input logic [NIB_W-1:0] f);
    return f[NIB_W-1];
  endfunction

  // Block index within the upper half
  function automatic logic [BLK_BITS-1:0] block_idx(input logic [NIB_W-1:0] f);
    return f[BLK_BITS-1:0];
  endfunction

  // Active-low read strobe
  function automatic logic oe_n_of(input logic rw, input logic phase);
    return !(phase && rw);
  endfunction

  // Active-low write strobe
  function automatic logic we_n_of(input logic rw, input logic phase);
    return !(phase && !rw);
  endfunction
endpackage

// File: rtl/mmap_block_dec.sv
module mmap_block_dec #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [OUT_N-1:0] dec_n_o
);
  // One active-low output per block, all high while disabled
  for (genvar g = 0; g < OUT_N; g++) begin : g_out
    assign dec_n_o[g] = !(en_i && (sel_i == SEL_W'(g)));
  end
endmodule

// File: rtl/mmap_strobe_gen.sv
module mmap_strobe_gen (
  input  logic rw_i,
  input  logic phi2_i,
  output logic oe_n_o,
  output logic we_n_o
);
  import mmap_pkg::*;
  assign oe_n_o = oe_n_of(rw_i, phi2_i);
  assign we_n_o = we_n_of(rw_i, phi2_i);
endmodule

// File: rtl/mmap_cs_decoder.sv
module mmap_cs_decoder
  import mmap_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rw_i,
  input  logic                phi2_i,
  output logic                ram_cs_n_o,
  output logic                rom_cs_n_o,
  output logic [IO_SLOTS-1:0] io_cs_n_o,
  output logic                oe_n_o,
  output logic                we_n_o
);
  localparam int unsigned ROM_FIRST = NUM_BLK - ROM_BLKS;

  // Named internal events, visible to the bound checker
  logic [NIB_W-1:0]    top_f;
  logic                hi_half;
  logic [BLK_BITS-1:0] blk;
  logic [NUM_BLK-1:0]  blk_n;

  assign top_f   = top_field(addr_i);
  assign hi_half = upper_half(top_f);
  assign blk     = block_idx(top_f);

  // Lower half: RAM, selected by the top bit being clear
  assign ram_cs_n_o = hi_half;

  mmap_block_dec #(.SEL_W(BLK_BITS)) u_blk_dec (
    .en_i    (hi_half),
    .sel_i   (blk),
    .dec_n_o (blk_n)
  );

  // Active-low OR of the top blocks forms the ROM window
  assign rom_cs_n_o = &blk_n[NUM_BLK-1:ROM_FIRST];

  // Remaining blocks map to peripheral slots in ascending order
  for (genvar k = 0; k < IO_SLOTS; k++) begin : g_io
    assign io_cs_n_o[k] = blk_n[k];
  end

  mmap_strobe_gen u_strobe (
    .rw_i   (rw_i),
    .phi2_i (phi2_i),
    .oe_n_o (oe_n_o),
    .we_n_o (we_n_o)
  );
endmodule

// File: rtl/mmap_cs_decoder_chk.sv
module mmap_cs_decoder_chk
  import mmap_pkg::*;
(
  input logic [ADDR_W-1:0]   addr_i,
  input logic                rw_i,
  input logic                phi2_i,
  input logic                ram_cs_n_o,
  input logic                rom_cs_n_o,
  input logic [IO_SLOTS-1:0] io_cs_n_o,
  input logic                oe_n_o,
  input logic                we_n_o,
  input logic [NUM_BLK-1:0]  blk_n
);
  always_comb begin
    AST_ONE_SELECT: assert ($countones(~{ram_cs_n_o, rom_cs_n_o, io_cs_n_o}) == 1); // R5
    AST_RAM_LOWER_HALF: assert ((addr_i[ADDR_W-1] == 1'b0) == (ram_cs_n_o == 1'b0)); // R1
    AST_ROM_WINDOW: assert ((addr_i[ADDR_W-1:ADDR_W-3] == 3'b111) == (rom_cs_n_o == 1'b0)); // R3
    AST_BLOCK_ONEHOT: assert (addr_i[ADDR_W-1] ? ($countones(~blk_n) == 1) : (&blk_n)); // R2
    AST_STROBE_EXCL: assert (oe_n_o || we_n_o); // R6
    AST_STROBE_IDLE: assert (phi2_i || (oe_n_o && we_n_o)); // R8
    AST_WRITE_QUAL: assert (we_n_o || (phi2_i && !rw_i)); // R7
  end
endmodule

bind mmap_cs_decoder mmap_cs_decoder_chk chk_i (
  .addr_i     (addr_i),
  .rw_i       (rw_i),
  .phi2_i     (phi2_i),
  .ram_cs_n_o (ram_cs_n_o),
  .rom_cs_n_o (rom_cs_n_o),
  .io_cs_n_o  (io_cs_n_o),
  .oe_n_o     (oe_n_o),
  .we_n_o     (we_n_o),
  .blk_n      (blk_n)
);

// File: tb/mmap_cs_decoder_tb_top.sv
module mmap_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic [15:0] addr;
  logic        rw;
  logic        phi2;
  logic        ram_n, rom_n, oe_n, we_n;
  logic [5:0]  io_n;
  int          n_vec  = 0;
  int          n_fail = 0;
  int          cycles = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  mmap_cs_decoder dut_i (
    .addr_i (addr), .rw_i (rw), .phi2_i (phi2),
    .ram_cs_n_o (ram_n), .rom_cs_n_o (rom_n), .io_cs_n_o (io_n),
    .oe_n_o (oe_n), .we_n_o (we_n)
  );

  // Expected selects {ram, rom, io[5:0]} by memory-map lookup
  function automatic logic [7:0] exp_sel(input logic [15:0] a);
    logic [3:0] nib = a[15:12];
    if (nib < 4'h8)       return 8'b0111_1111;
    else if (nib >= 4'hE) return 8'b1011_1111;
    else                  return {2'b11, ~(6'b1 << (nib - 4'h8))};
  endfunction

  function automatic logic [1:0] exp_strb(input logic r, input logic p);
    // {oe_n, we_n}
    if (!p) return 2'b11;
    return r ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h rw=%b phi2=%b actual=%b expected=%b", req, addr, rw, phi2, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic r, input logic p);
    logic [7:0] es;
    logic [1:0] et;
    @(negedge clk);
    addr = a; rw = r; phi2 = p;
    @(posedge clk); #1;
    n_vec++;
    es = exp_sel(a);
    et = exp_strb(r, p);
    if (a[15] == 1'b0) chk("R1", {ram_n, rom_n, io_n}, es);
    else               chk("R2", {ram_n, rom_n, io_n}, es);
    chk("R3", {7'd0, rom_n}, {7'd0, es[6]});
    chk("R4", {2'd0, io_n}, {2'd0, es[5:0]});
    chk("R5", 8'($countones(~{ram_n, rom_n, io_n})), 8'd1);
    chk("R6", {7'd0, oe_n}, {7'd0, et[1]});
    chk("R7", {7'd0, we_n}, {7'd0, et[0]});
    if (!p) chk("R8", {6'd0, oe_n, we_n}, 8'b11);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] prev;
    addr = 16'h0000; rw = 1'b1; phi2 = 1'b0;
    void'($urandom(32'd2024));
    // Initial state: address zero, low phase
    apply(16'h0000, 1'b1, 1'b0);
    // R1 R2 R3 R4: every top nibble at both block edges, all strobe combinations
    for (int n = 0; n < 16; n++)
      for (int rp = 0; rp < 4; rp++) begin
        apply({n[3:0], 12'h000}, rp[0], rp[1]);
        apply({n[3:0], 12'hFFF}, rp[0], rp[1]);
      end
    // Boundary addresses of each region
    apply(16'h7FFF, 1'b0, 1'b1);
    apply(16'h8000, 1'b1, 1'b1);
    apply(16'hDFFF, 1'b0, 1'b1);
    apply(16'hE000, 1'b1, 1'b1);
    apply(16'hFFFF, 1'b1, 1'b0);
    // R9: only low bits change, selects must not move
    for (int i = 0; i < 64; i++) begin
      prev = 16'($urandom);
      apply(prev, 1'b1, 1'b1);
      apply({prev[15:12], 12'($urandom)}, 1'b0, 1'b1);
    end
    // Random vectors (R9: back-to-back changes settle with no extra edge)
    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 1'($urandom), 1'($urandom));
    finish_run();
  end
endmodule